// File: doc/BRIEF.md
# Serial Character Receiver with Line Error Detection

The block rebuilds asynchronous serial characters from a single receive line. A baud tick at sixteen times the bit rate paces it. Each character is 5 to 8 data bits, sent least significant bit first, with an optional parity bit and at least one stop bit. Every completed character is offered to an external receive FIFO through a one-cycle push strobe. The same completion cycle carries single-cycle pulses for parity errors, framing errors, overruns and breaks. The FIFO storage is outside the block; only its fill count and full flag come back in.

An idle timer raises a level flag when characters wait in the FIFO and the line stays quiet for four character times. The request-to-send output is active low and has two sources. With hardware flow control off, it follows a control bit. With hardware flow control on, it follows the FIFO fill level.

Top module: `urx_engine`

## Requirements
- R1: After reset, push_valid and all four error pulses are low, rx_timeout is low and rtsn is high.
- R2: A falling edge on rxd starts a frame only if the line is still low eight baud ticks later. A low pulse shorter than that produces no push and no error.
- R3: cfg_len selects the number of data bits: 0 gives 5, 1 gives 6, 2 gives 7 and 3 gives 8. Bits arrive least significant bit first. push_data holds them right-aligned with the unused upper bits zero. push_valid is high for exactly one cycle per accepted frame.
- R4: When cfg_par_en is 1, a parity bit follows the data. cfg_par_odd=1 means odd parity over data plus parity bit, and 0 means even. On a mismatch, err_parity pulses in the push cycle and the character is still delivered.
- R5: A stop bit sampled low pulses err_frame and the character is still delivered. The receiver then waits for rxd to return high before it looks for a new start bit.
- R6: A frame in which every bit, stop bit included, is low pulses err_break together with err_frame, and pushes the value zero.
- R7: If fifo_full is high when a frame completes, err_overrun pulses, push_valid stays low and the character is dropped. Parity and framing errors are still reported.
- R8: rx_timeout rises after (7 + cfg_len + cfg_par_en) × 64 baud ticks during which fifo_count is nonzero, rxd is high and no frame is in progress. It falls within two cycles after fifo_count becomes zero.
- R9: With hwfc_en=0, rtsn equals the inverse of rts_ctl one cycle later, whatever fifo_count is.
- R10: With hwfc_en=1, rtsn is high one cycle after fifo_count is at or above RTS_LEVEL (default 12), and low one cycle after it is below.
- R11: err_parity, err_frame, err_overrun and err_break are each high for at most one cycle per frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| baud_tick | input | 1 | One-cycle strobe at 16× the bit rate |
| rxd | input | 1 | Serial receive line, idle high |
| cfg_len | input | 2 | Data length code (0..3 gives 5..8 bits) |
| cfg_par_en | input | 1 | Parity bit present |
| cfg_par_odd | input | 1 | 1 selects odd parity, 0 selects even |
| fifo_count | input | CNT_W | Receive FIFO fill count |
| fifo_full | input | 1 | Receive FIFO full |
| hwfc_en | input | 1 | Drive rtsn from the FIFO level |
| rts_ctl | input | 1 | Manual request-to-send, active high |
| push_data | output | 8 | Received character, right-aligned |
| push_valid | output | 1 | One-cycle push strobe |
| err_parity | output | 1 | Parity error pulse |
| err_frame | output | 1 | Framing error pulse |
| err_overrun | output | 1 | Overrun pulse, character dropped |
| err_break | output | 1 | Break pulse |
| rx_timeout | output | 1 | Idle timeout level |
| rtsn | output | 1 | Request-to-send, active low |

## Verification
All of a frame's verdicts arrive in its completion cycle. An overrun can therefore coincide with a parity error, and a break always coincides with a framing error. The first pair is provoked by holding fifo_full high while sending a frame whose parity bit is inverted. It is judged by seeing err_overrun and err_parity high in the same sampled cycle with no push. The break pair is provoked by an all-low frame that stays low past its stop bit. It is judged by one break pulse, one framing pulse and exactly one zero push, with no second frame while the line stays low.

// File: rtl/urx_pkg.sv
package urx_pkg;
  localparam int RX_DW = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP,
    ST_HOLD
  } rx_state_e;

  typedef struct packed {
    logic parity;
    logic frame;
    logic overrun;
    logic brk;
  } rx_err_t;
endpackage

// File: rtl/urx_sync.sv
module urx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sr_q, sr_d;

  always_comb sr_d = {sr_q[STAGES-2:0], d};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sr_q <= '1;
    else        sr_q <= sr_d;
  end

  assign q = sr_q[STAGES-1];
endmodule

// File: rtl/urx_framer.sv
module urx_framer
  import urx_pkg::*;
#(
  parameter int OVS = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             rx,
  input  logic [1:0]       cfg_len,
  input  logic             cfg_par_en,
  input  logic             cfg_par_odd,
  input  logic             fifo_full,
  output logic [RX_DW-1:0] data_o,
  output logic             push_o,
  output rx_err_t          err_o,
  output logic             busy_o
);
  localparam int OVS_W = $clog2(OVS);
  localparam int BIT_W = $clog2(RX_DW);
  localparam logic [OVS_W-1:0] MID  = OVS_W'(OVS/2 - 1);
  localparam logic [OVS_W-1:0] LAST = OVS_W'(OVS - 1);

  rx_state_e        state_q, state_d;
  logic [OVS_W-1:0] tcnt_q, tcnt_d;
  logic [BIT_W-1:0] bidx_q, bidx_d;
  logic [RX_DW-1:0] shreg_q, shreg_d;
  logic             xor_q, xor_d, ones_q, ones_d, perr_q, perr_d;
  logic [RX_DW-1:0] data_q, data_d;
  logic             push_q, push_d;
  rx_err_t          err_q, err_d;
  logic             bit_smp;
  logic [BIT_W-1:0] last_idx;

  assign last_idx = BIT_W'(4) + BIT_W'(cfg_len);
  assign bit_smp  = tick && (tcnt_q == LAST);

  always_comb begin
    state_d = state_q;
    tcnt_d  = tcnt_q;
    bidx_d  = bidx_q;
    shreg_d = shreg_q;
    xor_d   = xor_q;
    ones_d  = ones_q;
    perr_d  = perr_q;
    data_d  = data_q;
    push_d  = 1'b0;
    err_d   = '0;
    if (tick && state_q != ST_IDLE && state_q != ST_HOLD)
      tcnt_d = (tcnt_q == LAST) ? '0 : tcnt_q + 1'b1;
    unique case (state_q)
      ST_IDLE: begin
        tcnt_d = '0;
        if (tick && !rx) state_d = ST_START;
      end
      ST_START: begin
        if (tick && tcnt_q == MID) begin
          tcnt_d = '0;
          bidx_d = '0;
          xor_d  = 1'b0;
          ones_d = 1'b0;
          perr_d = 1'b0;
          state_d = rx ? ST_IDLE : ST_DATA;
        end
      end
      ST_DATA: begin
        if (bit_smp) begin
          shreg_d = {rx, shreg_q[RX_DW-1:1]};
          xor_d   = xor_q ^ rx;
          ones_d  = ones_q | rx;
          if (bidx_q == last_idx) state_d = cfg_par_en ? ST_PAR : ST_STOP;
          else                    bidx_d  = bidx_q + 1'b1;
        end
      end
      ST_PAR: begin
        if (bit_smp) begin
          perr_d  = xor_q ^ rx ^ cfg_par_odd;
          ones_d  = ones_q | rx;
          state_d = ST_STOP;
        end
      end
      ST_STOP: begin
        if (bit_smp) begin
          data_d       = shreg_q >> (2'd3 - cfg_len);
          err_d.frame  = !rx;
          err_d.brk    = !rx && !ones_q;
          err_d.parity = cfg_par_en && perr_q;
          err_d.overrun = fifo_full;
          push_d       = !fifo_full;
          state_d      = rx ? ST_IDLE : ST_HOLD;
        end
      end
      ST_HOLD: begin
        if (rx) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      tcnt_q  <= '0;
      bidx_q  <= '0;
      shreg_q <= '0;
      xor_q   <= 1'b0;
      ones_q  <= 1'b0;
      perr_q  <= 1'b0;
      data_q  <= '0;
      push_q  <= 1'b0;
      err_q   <= '0;
    end else begin
      state_q <= state_d;
      tcnt_q  <= tcnt_d;
      bidx_q  <= bidx_d;
      shreg_q <= shreg_d;
      xor_q   <= xor_d;
      ones_q  <= ones_d;
      perr_q  <= perr_d;
      data_q  <= data_d;
      push_q  <= push_d;
      err_q   <= err_d;
    end
  end

  assign data_o = data_q;
  assign push_o = push_q;
  assign err_o  = err_q;
  assign busy_o = (state_q != ST_IDLE);
endmodule

// File: rtl/urx_idle_timer.sv
module urx_idle_timer #(
  parameter int OVS      = 16,
  parameter int TO_CHARS = 4,
  parameter int CNT_W    = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             line_idle,
  input  logic [CNT_W-1:0] fifo_count,
  input  logic [1:0]       cfg_len,
  input  logic             cfg_par_en,
  output logic             timeout_o
);
  localparam int MAXLIM = 12 * TO_CHARS * OVS;
  localparam int LIM_W  = $clog2(MAXLIM + 1);

  logic [LIM_W-1:0] frame_bits, limit;
  logic [LIM_W-1:0] cnt_q, cnt_d;

  assign frame_bits = LIM_W'(7) + LIM_W'(cfg_len) + LIM_W'(cfg_par_en);
  assign limit      = frame_bits * LIM_W'(TO_CHARS * OVS);

  always_comb begin
    cnt_d = cnt_q;
    if (fifo_count == '0 || !line_idle) cnt_d = '0;
    else if (tick && cnt_q < limit)     cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign timeout_o = (cnt_q != '0) && (cnt_q >= limit);
endmodule

// File: rtl/urx_flow.sv
module urx_flow #(
  parameter int CNT_W     = 5,
  parameter int RTS_LEVEL = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hwfc_en,
  input  logic             rts_ctl,
  input  logic [CNT_W-1:0] fifo_count,
  output logic             rtsn_o
);
  logic rtsn_q, rtsn_d;

  always_comb begin
    if (hwfc_en) rtsn_d = (fifo_count >= CNT_W'(RTS_LEVEL));
    else         rtsn_d = !rts_ctl;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rtsn_q <= 1'b1;
    else        rtsn_q <= rtsn_d;
  end

  assign rtsn_o = rtsn_q;
endmodule

// File: rtl/urx_engine.sv
module urx_engine
  import urx_pkg::*;
#(
  parameter int OVS         = 16,
  parameter int SYNC_STAGES = 2,
  parameter int FIFO_DEPTH  = 16,
  parameter int RTS_LEVEL   = 12,
  parameter int TO_CHARS    = 4,
  localparam int CNT_W      = $clog2(FIFO_DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             baud_tick,
  input  logic             rxd,
  input  logic [1:0]       cfg_len,
  input  logic             cfg_par_en,
  input  logic             cfg_par_odd,
  input  logic [CNT_W-1:0] fifo_count,
  input  logic             fifo_full,
  input  logic             hwfc_en,
  input  logic             rts_ctl,
  output logic [7:0]       push_data,
  output logic             push_valid,
  output logic             err_parity,
  output logic             err_frame,
  output logic             err_overrun,
  output logic             err_break,
  output logic             rx_timeout,
  output logic             rtsn
);
  logic    rx_s, busy;
  rx_err_t err;

  urx_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rst_n(rst_n), .d(rxd), .q(rx_s)
  );

  urx_framer #(.OVS(OVS)) framer_i (
    .clk(clk), .rst_n(rst_n), .tick(baud_tick), .rx(rx_s),
    .cfg_len(cfg_len), .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd),
    .fifo_full(fifo_full), .data_o(push_data), .push_o(push_valid),
    .err_o(err), .busy_o(busy)
  );

  urx_idle_timer #(.OVS(OVS), .TO_CHARS(TO_CHARS), .CNT_W(CNT_W)) timer_i (
    .clk(clk), .rst_n(rst_n), .tick(baud_tick), .line_idle(rx_s && !busy),
    .fifo_count(fifo_count), .cfg_len(cfg_len), .cfg_par_en(cfg_par_en),
    .timeout_o(rx_timeout)
  );

  urx_flow #(.CNT_W(CNT_W), .RTS_LEVEL(RTS_LEVEL)) flow_i (
    .clk(clk), .rst_n(rst_n), .hwfc_en(hwfc_en), .rts_ctl(rts_ctl),
    .fifo_count(fifo_count), .rtsn_o(rtsn)
  );

  assign err_parity  = err.parity;
  assign err_frame   = err.frame;
  assign err_overrun = err.overrun;
  assign err_break   = err.brk;
endmodule

// File: rtl/urx_engine_chk.sv
module urx_engine_chk #(
  parameter int CNT_W     = 5,
  parameter int RTS_LEVEL = 12
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cfg_par_en,
  input logic [CNT_W-1:0] fifo_count,
  input logic             fifo_full,
  input logic             hwfc_en,
  input logic             rts_ctl,
  input logic             push_valid,
  input logic             err_parity,
  input logic             err_frame,
  input logic             err_overrun,
  input logic             err_break,
  input logic             rx_timeout,
  input logic             rtsn
);
  assert_push_xor_ovr_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(push_valid && err_overrun));
  assert_ovr_full_R7: assert property (@(posedge clk) disable iff (!rst_n)
    err_overrun |-> $past(fifo_full));
  assert_brk_frame_R6: assert property (@(posedge clk) disable iff (!rst_n)
    err_break |-> err_frame);
  assert_par_cfg_R4: assert property (@(posedge clk) disable iff (!rst_n)
    err_parity |-> $past(cfg_par_en));
  assert_push_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    push_valid |=> !push_valid);
  assert_frame_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (err_frame || err_parity || err_overrun) |=> !(err_frame || err_parity || err_overrun));
  assert_to_nonempty_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rx_timeout |-> $past(fifo_count != '0));
  assert_rts_auto_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (hwfc_en && fifo_count >= CNT_W'(RTS_LEVEL)) |=> rtsn);
  assert_rts_manual_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!hwfc_en && rts_ctl) |=> !rtsn);
endmodule

bind urx_engine urx_engine_chk #(.CNT_W(CNT_W), .RTS_LEVEL(RTS_LEVEL)) chk_i (.*);

// File: tb/urx_engine_tb_top.sv
`timescale 1ns/1ps
module urx_engine_tb_top;
  localparam int DEPTH = 16;
  localparam int LEVEL = 12;
  localparam int CW    = $clog2(DEPTH + 1);

  logic clk = 1'b0, rst_n = 1'b0, baud_tick = 1'b0, rxd = 1'b1;
  logic [1:0] cfg_len = 2'd3, tdiv = 2'd0;
  logic cfg_par_en = 1'b0, cfg_par_odd = 1'b0, fifo_full = 1'b0;
  logic hwfc_en = 1'b0, rts_ctl = 1'b0;
  logic [CW-1:0] fifo_count = '0;
  logic [7:0] push_data;
  logic push_valid, err_parity, err_frame, err_overrun, err_break, rx_timeout, rtsn;

  int n_cmp = 0, n_bad = 0;
  int n_push = 0, n_par = 0, n_frm = 0, n_ovr = 0, n_brk = 0;
  bit par_with_ovr = 0, done = 0;
  logic [7:0] last_data = '0;

  always #2 clk = ~clk;

  always @(negedge clk) begin
    tdiv      <= tdiv + 2'd1;
    baud_tick <= (tdiv == 2'd3);
  end

  urx_engine #(.FIFO_DEPTH(DEPTH), .RTS_LEVEL(LEVEL)) dut_i (
    .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .rxd(rxd),
    .cfg_len(cfg_len), .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd),
    .fifo_count(fifo_count), .fifo_full(fifo_full), .hwfc_en(hwfc_en),
    .rts_ctl(rts_ctl), .push_data(push_data), .push_valid(push_valid),
    .err_parity(err_parity), .err_frame(err_frame), .err_overrun(err_overrun),
    .err_break(err_break), .rx_timeout(rx_timeout), .rtsn(rtsn)
  );

  always @(negedge clk) begin
    if (rst_n) begin
      if (push_valid) begin n_push++; last_data = push_data; end
      if (err_parity) n_par++;
      if (err_frame) n_frm++;
      if (err_overrun) n_ovr++;
      if (err_break) n_brk++;
      if (err_overrun && err_parity) par_with_ovr = 1;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic clear_mon();
    n_push = 0; n_par = 0; n_frm = 0; n_ovr = 0; n_brk = 0; par_with_ovr = 0;
  endtask

  task automatic wait_ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      while (!baud_tick) @(posedge clk);
    end
    @(negedge clk);
  endtask

  task automatic drive(input logic v, input int ticks);
    rxd = v;
    wait_ticks(ticks);
  endtask

  task automatic send_frame(input logic [7:0] d, input int nb, input bit pen,
                            input bit podd, input bit flip, input logic stopv,
                            input int extra_low);
    logic p;
    p = 1'b0;
    drive(1'b0, 16);
    for (int i = 0; i < nb; i++) begin
      drive(d[i], 16);
      p = p ^ d[i];
    end
    if (pen) drive(p ^ podd ^ flip, 16);
    drive(stopv, 16 + (stopv ? 0 : extra_low));
    drive(1'b1, 16);
  endtask

  initial begin
    #(190000 * 4);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] pats [4];
    int nb, lim;
    logic [7:0] exp_d;
    pats[0] = 8'h00; pats[1] = 8'hFF; pats[2] = 8'hA5; pats[3] = 8'h3C;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(!push_valid && !err_parity && !err_frame && !err_overrun && !err_break,
        "R1", "pulses after reset", push_valid, 0);
    chk(!rx_timeout, "R1", "timeout after reset", rx_timeout, 0);
    chk(rtsn == 1'b1, "R1", "rtsn after reset", rtsn, 1);

    // R3 R4: sweep lengths, parity modes and patterns
    for (int l = 0; l < 4; l++)
      for (int pe = 0; pe < 2; pe++)
        for (int po = 0; po < 2; po++)
          for (int k = 0; k < 4; k++) begin
            cfg_len = 2'(l); cfg_par_en = pe[0]; cfg_par_odd = po[0];
            nb = 5 + l;
            exp_d = pats[k] & 8'((1 << nb) - 1);
            clear_mon();
            send_frame(pats[k], nb, pe[0], po[0], 1'b0, 1'b1, 0);
            chk(n_push == 1, "R3", "push count", n_push, 1);
            chk(last_data == exp_d, "R3", "data", last_data, exp_d);
            chk(n_par == 0 && n_frm == 0 && n_brk == 0 && n_ovr == 0,
                "R4", "spurious error", n_par + n_frm + n_brk + n_ovr, 0);
          end

    // R4 parity mismatch, R11 single pulse
    for (int l = 0; l < 4; l++)
      for (int po = 0; po < 2; po++) begin
        cfg_len = 2'(l); cfg_par_en = 1'b1; cfg_par_odd = po[0];
        nb = 5 + l;
        clear_mon();
        send_frame(8'h5A, nb, 1'b1, po[0], 1'b1, 1'b1, 0);
        chk(n_par == 1, "R11", "parity pulse count", n_par, 1);
        chk(n_push == 1 && last_data == (8'h5A & 8'((1 << nb) - 1)),
            "R4", "data kept on parity error", last_data, 8'h5A & 8'((1 << nb) - 1));
      end

    // R5 framing error without break
    cfg_len = 2'd3; cfg_par_en = 1'b0; cfg_par_odd = 1'b0;
    clear_mon();
    send_frame(8'h81, 8, 1'b0, 1'b0, 1'b0, 1'b0, 0);
    chk(n_frm == 1, "R5", "framing pulse", n_frm, 1);
    chk(n_brk == 0, "R5", "no break on nonzero frame", n_brk, 0);
    chk(n_push == 1 && last_data == 8'h81, "R5", "data on framing error", last_data, 8'h81);

    // R6 break held low beyond the frame, R5 no restart while low
    clear_mon();
    send_frame(8'h00, 8, 1'b0, 1'b0, 1'b0, 1'b0, 200);
    chk(n_brk == 1, "R6", "break pulse", n_brk, 1);
    chk(n_frm == 1, "R6", "framing with break", n_frm, 1);
    chk(n_push == 1 && last_data == 8'h00, "R6", "single zero push", n_push, 1);

    // R7 overrun coinciding with parity error
    cfg_par_en = 1'b1; fifo_full = 1'b1;
    clear_mon();
    send_frame(8'h33, 8, 1'b1, 1'b0, 1'b1, 1'b1, 0);
    fifo_full = 1'b0;
    chk(n_ovr == 1, "R7", "overrun pulse", n_ovr, 1);
    chk(n_push == 0, "R7", "no push when full", n_push, 0);
    chk(par_with_ovr, "R7", "parity and overrun same cycle", par_with_ovr, 1);
    cfg_par_en = 1'b0;

    // R2 short low glitch, then a good frame
    clear_mon();
    drive(1'b0, 3);
    drive(1'b1, 48);
    chk(n_push == 0 && n_frm == 0, "R2", "glitch ignored", n_push + n_frm, 0);
    send_frame(8'hC7, 8, 1'b0, 1'b0, 1'b0, 1'b1, 0);
    chk(n_push == 1 && last_data == 8'hC7, "R2", "frame after glitch", last_data, 8'hC7);

    // R8 idle timeout for two configurations
    for (int c = 0; c < 2; c++) begin
      cfg_len = (c == 0) ? 2'd3 : 2'd0;
      cfg_par_en = (c == 0) ? 1'b0 : 1'b1;
      lim = (7 + int'(cfg_len) + int'(cfg_par_en)) * 64;
      chk(!rx_timeout, "R8", "no timeout when empty", rx_timeout, 0);
      fifo_count = CW'(1);
      wait_ticks(lim - 20);
      chk(!rx_timeout, "R8", "timeout early", rx_timeout, 0);
      wait_ticks(30);
      chk(rx_timeout, "R8", "timeout late", rx_timeout, 1);
      fifo_count = '0;
      @(negedge clk); @(negedge clk);
      chk(!rx_timeout, "R8", "timeout clears", rx_timeout, 0);
    end

    // R9 manual rts, fifo level ignored
    hwfc_en = 1'b0;
    for (int v = 0; v < 2; v++)
      for (int f = 0; f < 2; f++) begin
        rts_ctl = v[0];
        fifo_count = f ? CW'(DEPTH) : '0;
        @(negedge clk); @(negedge clk);
        chk(rtsn == !v[0], "R9", "manual rtsn", rtsn, !v[0]);
      end

    // R10 automatic rts over every fill level
    hwfc_en = 1'b1; rts_ctl = 1'b1;
    for (int n = 0; n <= DEPTH; n++) begin
      fifo_count = CW'(n);
      @(negedge clk); @(negedge clk);
      chk(rtsn == (n >= LEVEL), "R10", "auto rtsn", rtsn, n >= LEVEL);
    end
    fifo_count = '0;

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule